// File: doc/BRIEF.md
# Three-Mode Pulse Timer

This block is an 8-bit up-counter with three selectable modes. It counts ticks of an internal prescaled enable, counts edges on an external pin, or measures the period and the high or low time of that pin. The last use suits remote-control waveform decoding. Two 8-bit registers hold results. The first, the limit/period register, is a compare limit in the two counting modes and the period result in measuring mode. The second, the snapshot/width register, receives a copy of the count on request in the counting modes and holds the pulse width in measuring mode.

The external pin passes through a two-flop synchroniser and an edge detector. In measuring mode, each result for the limit/period register closes the capture window, whether it is a period or an overflow marker. No further result is taken until software reads that register and signals the read with a one-cycle strobe. Two sticky interrupt flags report events: one for a limit match or a period capture, and one for an overflow. Each flag is cleared by a one-cycle pulse.

Top module: `pulse_timer`

## Requirements
- R1: During and right after reset (synchronous, active low), count, limit/period register, snapshot/width register, both flags and snap_busy are all zero, and the capture window is open.
- R2: Mode 0 (timer): on each cycle with tick_en high, if count equals the limit register, count becomes 0 and the match flag sets; otherwise count increments. Pin edges have no effect.
- R3: Mode 1 (counter): count advances on the primary pin edge (edge_fall=0 selects rising, edge_fall=1 selects falling), with the same limit match as R2. The opposite edge and tick_en have no effect. A pin change driven before a clock edge changes count at the third clock edge after it.
- R4: In modes 0 and 1, a one-cycle snap_req pulse raises snap_busy after the next clock edge. At the edge that follows, snap_busy returns to 0 and the snapshot register takes the count.
- R5: lim_wr loads lim_wdata into the limit register in modes 0 and 1 and is ignored in mode 2.
- R6: Mode 2 (measure): count runs on tick_en. A primary pin edge with the window open loads count into the limit/period register, clears count, sets the match flag and closes the window.
- R7: Mode 2: the opposite pin edge with the window open loads count into the snapshot/width register and leaves count running.
- R8: Mode 2: a tick with count at 255 and the window open loads 255 into the limit/period register, sets the overflow flag and closes the window. Count wraps to 0.
- R9: While the window is closed, count keeps running, but pin edges and overflow change neither register nor any flag. A lim_rd pulse opens the window again.
- R10: Flags stay set until their clear input is pulsed. A set in the same cycle as a clear wins.
- R11: A change of the mode input clears count and reopens the capture window at the next clock edge.
- R12: Mode 3 holds count still.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Prescaled internal count enable |
| pin_in | input | 1 | Asynchronous external pin |
| mode | input | 2 | 0 timer, 1 counter, 2 measure, 3 hold |
| edge_fall | input | 1 | Primary edge: 0 rising, 1 falling |
| snap_req | input | 1 | Request a count snapshot (modes 0 and 1) |
| lim_wr | input | 1 | Write strobe for the limit register |
| lim_wdata | input | 8 | Data for the limit register |
| lim_rd | input | 1 | Limit/period register has been read; reopens the window |
| clr_match | input | 1 | Clear the match/capture flag |
| clr_ovf | input | 1 | Clear the overflow flag |
| count | output | 8 | Current counter value |
| lim_reg | output | 8 | Limit/period register |
| snap_reg | output | 8 | Snapshot/width register |
| snap_busy | output | 1 | Snapshot pending |
| irq_match | output | 1 | Sticky match/capture flag |
| irq_ovf | output | 1 | Sticky overflow flag |

## Verification
Timer mode is driven with ticks up to and one past the limit, which separates a compare before the increment from a compare after it. Counter mode is driven with alternating pin levels under both edge selections, plus a delay probe. These show whether the correct edge is counted and whether the synchroniser latency is exactly two flops plus the edge stage. Measuring mode is given distinct tick counts between the edges, so that the period and width results cannot be mixed up. It is then driven with edges and a full wrap while the window is closed, then with the wrap after a read, and finally across a mode switch. This separates the lock, the overflow marker and the reopening of the window.

// File: rtl/ptmr_pkg.sv
// Shared definitions for the pulse timer.
// Assumes a 2-bit mode field; value 3 is a hold state.
package ptmr_pkg;
    typedef enum logic [1:0] {
        PT_TIMER   = 2'd0,
        PT_COUNT   = 2'd1,
        PT_MEASURE = 2'd2,
        PT_HOLD    = 2'd3
    } pt_mode_e;
endpackage

// File: rtl/ptmr_sync_edge.sv
// Synchronises an asynchronous pin through STAGES flops and flags
// rising and falling edges by comparing the last two synced samples.
// Assumes the pin is low while reset is held.
module ptmr_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the pin through the synchroniser and keep one older sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            prev_q <= sync_q[STAGES-1];
        end
    end

    // Compare the current and previous synced samples.
    always_comb begin
        rise = sync_q[STAGES-1] & ~prev_q;
        fall = ~sync_q[STAGES-1] & prev_q;
    end

    AST_EDGE_NOT_REPEATED: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R3
endmodule

// File: rtl/ptmr_flags.sv
// N sticky flags: each is set by a one-cycle event and cleared by a pulse.
// A set in the same cycle as a clear wins.
module ptmr_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flag
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // Hold, set or clear one flag.
        always_ff @(posedge clk) begin
            if (!rst_n)      flag[i] <= 1'b0;
            else if (set[i]) flag[i] <= 1'b1;
            else if (clr[i]) flag[i] <= 1'b0;
        end

        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[i] && !clr[i]) |=> flag[i]); // R10
    end
endmodule

// File: rtl/ptmr_core.sv
// Counter, limit/period and snapshot/width registers, and the capture
// window lock. Edge inputs come pre-synchronised. Event outputs are
// combinational pulses that are valid in the cycle of the register update.
module ptmr_core
    import ptmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  pt_mode_e     mode,
    input  logic         tick_en,
    input  logic         rise,
    input  logic         fall,
    input  logic         edge_fall,
    input  logic         snap_req,
    input  logic         lim_wr,
    input  logic [W-1:0] lim_wdata,
    input  logic         lim_rd,
    output logic [W-1:0] count,
    output logic [W-1:0] lim_reg,
    output logic [W-1:0] snap_reg,
    output logic         snap_busy,
    output logic         match_evt,
    output logic         ovf_evt
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    pt_mode_e mode_q;
    logic     lock_q;
    logic     mode_chg, counting_mode, measure_on;
    logic     primary, secondary, step_evt, hit;
    logic     pri_cap, sec_cap;

    // Decode the events of this cycle from the mode and the edges.
    always_comb begin
        mode_chg      = (mode != mode_q);
        counting_mode = (mode_q == PT_TIMER) || (mode_q == PT_COUNT);
        primary       = edge_fall ? fall : rise;
        secondary     = edge_fall ? rise : fall;
        step_evt      = !mode_chg && (((mode_q == PT_TIMER) && tick_en) ||
                                      ((mode_q == PT_COUNT) && primary));
        hit           = step_evt && (count == lim_reg);
        measure_on    = !mode_chg && (mode_q == PT_MEASURE) && !lock_q;
        pri_cap       = measure_on && primary;
        sec_cap       = measure_on && secondary;
        ovf_evt       = measure_on && tick_en && !primary && (count == MAXV);
        match_evt     = hit || pri_cap;
    end

    // Track the mode so that a change can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= PT_TIMER;
        else        mode_q <= mode;
    end

    // Advance, clear or hold the counter.
    always_ff @(posedge clk) begin
        if (!rst_n || mode_chg) begin
            count <= '0;
        end else begin
            case (mode_q)
                PT_TIMER, PT_COUNT: if (step_evt) count <= hit ? '0 : count + 1'b1;
                PT_MEASURE: begin
                    if (pri_cap)      count <= '0;
                    else if (tick_en) count <= count + 1'b1;
                end
                default: count <= count;
            endcase
        end
    end

    // Load the limit/period register from a write, a period capture or an overflow.
    always_ff @(posedge clk) begin
        if (!rst_n)                         lim_reg <= '0;
        else if (lim_wr && counting_mode)   lim_reg <= lim_wdata;
        else if (pri_cap)                   lim_reg <= count;
        else if (ovf_evt)                   lim_reg <= MAXV;
    end

    // Load the snapshot/width register from a snapshot or a width capture.
    always_ff @(posedge clk) begin
        if (!rst_n)                         snap_reg <= '0;
        else if (snap_busy && counting_mode) snap_reg <= count;
        else if (sec_cap)                   snap_reg <= count;
    end

    // Hold a snapshot request for one cycle, then clear it.
    always_ff @(posedge clk) begin
        if (!rst_n || mode_chg) snap_busy <= 1'b0;
        else                    snap_busy <= snap_req && counting_mode;
    end

    // Close the capture window on a result and reopen it on a read.
    always_ff @(posedge clk) begin
        if (!rst_n || mode_chg)    lock_q <= 1'b0;
        else if (pri_cap || ovf_evt) lock_q <= 1'b1;
        else if (lim_rd)           lock_q <= 1'b0;
    end

    AST_MODE_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> (count == '0) && !lock_q); // R11
    AST_LIMIT_HIT_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (count == '0)); // R2
    AST_PERIOD_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        pri_cap |=> (count == '0) && lock_q); // R6
    AST_OVF_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> (lim_reg == MAXV) && lock_q); // R8
    AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && (mode_q == PT_MEASURE) && !mode_chg) |=>
        ($stable(lim_reg) && $stable(snap_reg))); // R9
    AST_SNAP_SELF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_busy && !snap_req) |=> !snap_busy); // R4
    AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == PT_HOLD) && !mode_chg) |=> $stable(count)); // R12
endmodule

// File: rtl/pulse_timer.sv
// Top level: synchroniser/edge detector, counter core and sticky flags.
// Assumes pin_in is low during reset and that the register reads and
// writes arrive as one-cycle strobes.
module pulse_timer
    import ptmr_pkg::*;
#(
    parameter int W          = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         pin_in,
    input  logic [1:0]   mode,
    input  logic         edge_fall,
    input  logic         snap_req,
    input  logic         lim_wr,
    input  logic [W-1:0] lim_wdata,
    input  logic         lim_rd,
    input  logic         clr_match,
    input  logic         clr_ovf,
    output logic [W-1:0] count,
    output logic [W-1:0] lim_reg,
    output logic [W-1:0] snap_reg,
    output logic         snap_busy,
    output logic         irq_match,
    output logic         irq_ovf
);
    logic       rise, fall, match_evt, ovf_evt;
    logic [1:0] flags;

    ptmr_sync_edge #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(pin_in), .rise(rise), .fall(fall)
    );

    ptmr_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .mode(pt_mode_e'(mode)), .tick_en(tick_en),
        .rise(rise), .fall(fall), .edge_fall(edge_fall), .snap_req(snap_req),
        .lim_wr(lim_wr), .lim_wdata(lim_wdata), .lim_rd(lim_rd),
        .count(count), .lim_reg(lim_reg), .snap_reg(snap_reg),
        .snap_busy(snap_busy), .match_evt(match_evt), .ovf_evt(ovf_evt)
    );

    ptmr_flags #(.N(2)) u_flags (
        .clk(clk), .rst_n(rst_n), .set({ovf_evt, match_evt}),
        .clr({clr_ovf, clr_match}), .flag(flags)
    );

    // Map the flag vector to the named outputs.
    always_comb begin
        irq_match = flags[0];
        irq_ovf   = flags[1];
    end
endmodule

// File: tb/pulse_timer_test.sv
module pulse_timer_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0, pin_in = 1'b0, edge_fall = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       snap_req = 1'b0, lim_wr = 1'b0, lim_rd = 1'b0;
    logic [7:0] lim_wdata = 8'd0;
    logic       clr_match = 1'b0, clr_ovf = 1'b0;
    logic [7:0] count, lim_reg, snap_reg;
    logic       snap_busy, irq_match, irq_ovf;
    int         checks = 0, failures = 0;
    bit         done = 1'b0;

    pulse_timer uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .pin_in(pin_in),
        .mode(mode), .edge_fall(edge_fall), .snap_req(snap_req),
        .lim_wr(lim_wr), .lim_wdata(lim_wdata), .lim_rd(lim_rd),
        .clr_match(clr_match), .clr_ovf(clr_ovf), .count(count),
        .lim_reg(lim_reg), .snap_reg(snap_reg), .snap_busy(snap_busy),
        .irq_match(irq_match), .irq_ovf(irq_ovf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick(int n);
        tick_en = 1'b1;
        step(n);
        tick_en = 1'b0;
    endtask

    task automatic pin_to(logic v);
        pin_in = v;
        step(4);
    endtask

    task automatic write_lim(logic [7:0] v);
        lim_wr = 1'b1; lim_wdata = v; step(1); lim_wr = 1'b0;
    endtask

    task automatic read_lim();
        lim_rd = 1'b1; step(1); lim_rd = 1'b0;
    endtask

    task automatic clear_flags();
        clr_match = 1'b1; clr_ovf = 1'b1; step(1);
        clr_match = 1'b0; clr_ovf = 1'b0;
    endtask

    task automatic test_reset();
        step(3);
        check("R1", "count in reset", count, 0);
        rst_n = 1'b1;
        step(1);
        check("R1", "count", count, 0);
        check("R1", "lim_reg", lim_reg, 0);
        check("R1", "snap_reg", snap_reg, 0);
        check("R1", "flags", {irq_ovf, irq_match}, 0);
        check("R1", "snap_busy", snap_busy, 0);
    endtask

    task automatic test_timer();
        write_lim(8'd5);
        check("R5", "limit written in timer mode", lim_reg, 5);
        tick(5);
        check("R2", "count at limit", count, 5);
        check("R2", "no match yet", irq_match, 0);
        tick(1);
        check("R2", "count cleared on match", count, 0);
        check("R2", "match flag", irq_match, 1);
        pin_to(1'b1); pin_to(1'b0);
        check("R2", "pin ignored", count, 0);
        tick(3);
        snap_req = 1'b1; step(1); snap_req = 1'b0;
        check("R4", "snap busy", snap_busy, 1);
        step(1);
        check("R4", "snap cleared", snap_busy, 0);
        check("R4", "snapshot value", snap_reg, 3);
        step(2);
        check("R10", "match sticky", irq_match, 1);
        clr_match = 1'b1; step(1); clr_match = 1'b0;
        check("R10", "match cleared", irq_match, 0);
    endtask

    task automatic test_counter();
        mode = 2'd1; step(1);
        check("R11", "count cleared on mode change", count, 0);
        write_lim(8'd3);
        for (int i = 0; i < 3; i++) begin
            pin_to(1'b1); pin_to(1'b0);
        end
        check("R3", "three rising edges", count, 3);
        check("R3", "no match yet", irq_match, 0);
        tick(4);
        check("R3", "tick ignored", count, 3);
        pin_to(1'b1);
        check("R3", "match clears count", count, 0);
        check("R3", "match flag", irq_match, 1);
        pin_to(1'b0);
        check("R3", "falling ignored", count, 0);
        edge_fall = 1'b1; step(1);
        pin_to(1'b1);
        check("R3", "rising ignored when falling selected", count, 0);
        pin_to(1'b0);
        check("R3", "falling counted", count, 1);
        pin_in = 1'b1; step(4);
        pin_in = 1'b0; step(2);
        check("R3", "not yet after two edges", count, 1);
        step(1);
        check("R3", "counted at third edge", count, 2);
        edge_fall = 1'b0;
        clear_flags();
    endtask

    task automatic test_measure();
        mode = 2'd2; step(1);
        check("R11", "count cleared entering measure", count, 0);
        tick(10);
        pin_in = 1'b1; step(3);
        check("R6", "period captured", lim_reg, 10);
        check("R6", "count cleared", count, 0);
        check("R6", "capture flag", irq_match, 1);
        tick(4);
        read_lim();
        pin_in = 1'b0; step(3);
        check("R7", "width captured", snap_reg, 4);
        check("R7", "count not cleared", count, 4);
        tick(3);
        pin_in = 1'b1; step(3);
        check("R6", "second period", lim_reg, 7);
        clear_flags();
        pin_in = 1'b0; step(3);
        check("R9", "width frozen while locked", snap_reg, 4);
        tick(2);
        check("R9", "count runs while locked", count, 2);
        pin_in = 1'b1; step(3);
        check("R9", "period frozen while locked", lim_reg, 7);
        check("R9", "count not cleared while locked", count, 2);
        check("R9", "no flag while locked", irq_match, 0);
        write_lim(8'h33);
        check("R5", "write ignored in measure", lim_reg, 7);
        read_lim();
        tick(253);
        check("R8", "count at max", count, 255);
        tick(1);
        check("R8", "overflow marker", lim_reg, 255);
        check("R8", "count wrapped", count, 0);
        check("R8", "overflow flag", irq_ovf, 1);
        clear_flags();
        tick(256);
        check("R9", "no overflow while locked", irq_ovf, 0);
        check("R9", "count wrapped while locked", count, 0);
    endtask

    task automatic test_mode_switch();
        mode = 2'd0; step(1);
        tick(6);
        check("R2", "timer below limit 255", count, 6);
        mode = 2'd2; step(1);
        check("R11", "count cleared", count, 0);
        tick(5);
        pin_in = 1'b0; step(3);
        check("R11", "window reopened by mode change", snap_reg, 5);
        mode = 2'd3; step(1);
        tick(5);
        check("R12", "hold mode keeps count", count, 0);
    endtask

    initial begin
        test_reset();
        test_timer();
        test_counter();
        test_measure();
        test_mode_switch();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule